// File: doc/BRIEF.md
# Register-Exchange Survivor Path Unit

This block keeps the survivor history for a four-state trellis, the trellis of a rate-1/n convolutional code with constraint length 3. An external add-compare-select stage feeds it once per trellis step. Each step brings one decision bit per state and the index of the state that currently has the best metric. The unit holds one shift register per state, and that register is the sequence of information bits along the state's survivor path. On every accepted step, each state's register takes a copy of the register of the predecessor its decision picked, shifted one place toward the old end, with the state's own input bit added at the new end. The state's input bit is the most significant bit of its 2-bit index. Because each register already holds decoded bits in time order, no backward walk over stored decisions is needed.

A small controller with three named states sequences the unit. In FILL, registers are filling after reset or after a drain. RUN starts once the registers are full. In RUN, every accepted step emits the bit that falls off the old end of the best state's new register. DRAIN is entered on a flush request. It emits the bits still held in the best state's register, oldest first, one per cycle. The transitions are:

- FILL→RUN on the step that fills the registers.
- FILL→DRAIN or RUN→DRAIN on a flush while at least one step is held.
- FILL→FILL on a flush while no step is held.
- DRAIN→FILL on the last drained bit. This transition also clears every register and the step count.

Top module: `rx_survivor_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` is 0, all survivor registers are zero and the step count is zero.
- R2: After reset or after a drain, the first 15 accepted steps produce no output. `out_valid` is never high except as stated in R4 and R5.
- R3: On an accepted step, the new register of state s is the old register of predecessor p, shifted one place toward the old end, with bit s[1] appended at the new end. Here p = ((s<<1)&3) when `decision[s]` is 0 and p = ((s<<1)&3)|1 when it is 1.
- R4: While the registers are full (15 steps held), every accepted step is followed one cycle later by `out_valid`=1. `out_bit` then equals the oldest bit of the register of the predecessor chosen for `best_state`, which is the information bit 15 steps before the newest bit on the best path.
- R5: A flush request latches the register of `best_state`. The unit then emits min(steps held, 15) bits on consecutive cycles, oldest first, starting the cycle after the flush cycle.
- R6: After the last drained bit, the unit is back in FILL with all registers and the step count cleared.
- R7: While draining, `step_valid`, `flush`, `decision` and `best_state` have no effect.
- R8: A flush while no step is held emits nothing and leaves the unit in FILL.
- R9: A cycle with neither `step_valid` nor `flush` changes no register and no count, and emits nothing.
- R10: When `flush` and `step_valid` are high in the same cycle, the flush is taken and the step is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| step_valid | input | 1 | One trellis step is presented this cycle |
| decision | input | 4 | Per-state select between the two predecessors (1 = odd predecessor) |
| best_state | input | 2 | Index of the best-metric state for this step or flush |
| flush | input | 1 | Request to drain the best state's register |
| out_valid | output | 1 | `out_bit` carries a decoded bit |
| out_bit | output | 1 | Decoded information bit |

## Verification
The hardest situation to reach is an output that depends on a survivor of a state that is not the true path. That output must take its bits from a chain of copies through many different predecessors. The stimulus therefore draws every decision bit and every best-state index at random. It predicts each expected bit by walking backward through its own record of decisions, which is an independent traceback. It also drives random junk on every input while a drain is running. Flushes land at counts of zero, of fewer than 15 steps and of a full register, and some flushes share their cycle with a step. Idle cycles fall inside a stream. An error-free encoded sequence also checks that the true inputs come back.

// File: rtl/rx_pkg.sv
package rx_pkg;

    typedef enum logic [1:0] {
        CTL_FILL  = 2'd0,
        CTL_RUN   = 2'd1,
        CTL_DRAIN = 2'd2
    } ctl_state_e;

endpackage

// File: rtl/rx_surv_row.sv
module rx_surv_row #(
    parameter int LEN = 15,
    parameter int STW = 2,
    parameter int IDX = 0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           upd,
    input  logic           clr,
    input  logic           sel,
    input  logic [LEN-1:0] from_lo,
    input  logic [LEN-1:0] from_hi,
    output logic [LEN-1:0] hist
);

    localparam logic APPEND_BIT = 1'((IDX >> (STW - 1)) & 1);

    logic [LEN-1:0] pick;

    always_comb begin
        pick = sel ? from_hi : from_lo;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            hist <= '0;
        end else if (upd) begin
            hist <= {pick[LEN-2:0], APPEND_BIT};
        end
    end

    // R3: the newest bit of a row after an update is the row's own input bit
    p_append_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !clr) |=> (hist[0] == APPEND_BIT));

    // R9: without an update or a clear the row holds
    p_row_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd && !clr) |=> $stable(hist));

endmodule

// File: rtl/rx_ctrl.sv
module rx_ctrl
    import rx_pkg::*;
#(
    parameter int LEN = 15,
    parameter int CW  = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           step_valid,
    input  logic           flush,
    input  logic [LEN-1:0] best_row,
    input  logic           best_drop,
    output logic           upd,
    output logic           clr,
    output logic           out_valid,
    output logic           out_bit
);

    ctl_state_e     st_q, st_d;
    logic [CW-1:0]  cnt_q;
    logic [CW-1:0]  rem_q;
    logic [LEN-1:0] dq;
    logic           take_flush;
    logic           drain_last;
    logic           full;

    always_comb begin
        full       = (cnt_q == CW'(LEN));
        take_flush = flush && (st_q != CTL_DRAIN);
        upd        = step_valid && !flush && (st_q != CTL_DRAIN);
        drain_last = (st_q == CTL_DRAIN) && (rem_q == CW'(1));
        clr        = drain_last || (take_flush && (cnt_q == '0));
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CTL_FILL: begin
                if (take_flush) begin
                    st_d = (cnt_q == '0) ? CTL_FILL : CTL_DRAIN;
                end else if (upd && (cnt_q == CW'(LEN - 1))) begin
                    st_d = CTL_RUN;
                end
            end
            CTL_RUN: begin
                if (take_flush) begin
                    st_d = CTL_DRAIN;
                end
            end
            CTL_DRAIN: begin
                if (drain_last) begin
                    st_d = CTL_FILL;
                end
            end
            default: st_d = CTL_FILL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= CTL_FILL;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            rem_q     <= '0;
            dq        <= '0;
            out_valid <= 1'b0;
            out_bit   <= 1'b0;
        end else begin
            out_valid <= ((st_q == CTL_RUN) && upd) || (st_q == CTL_DRAIN);
            out_bit   <= (st_q == CTL_DRAIN) ? dq[rem_q - CW'(1)] : best_drop;
            if (clr) begin
                cnt_q <= '0;
            end else if (upd && !full) begin
                cnt_q <= cnt_q + CW'(1);
            end
            if (take_flush) begin
                rem_q <= cnt_q;
                dq    <= best_row;
            end else if (st_q == CTL_DRAIN) begin
                rem_q <= rem_q - CW'(1);
            end
        end
    end

    // R2: the step count never passes the register length
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LEN));

    // R2: nothing is emitted in the cycle after a FILL cycle
    p_fill_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CTL_FILL) |=> !out_valid);

    // R4: a valid output follows a stepped RUN cycle or a DRAIN cycle
    p_valid_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past((st_q == CTL_DRAIN) ||
                            ((st_q == CTL_RUN) && step_valid && !flush)));

    // R5: the drain counts down by one per cycle
    p_drain_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == CTL_DRAIN) && !drain_last) |=>
            ((st_q == CTL_DRAIN) && (rem_q == $past(rem_q) - CW'(1))));

    // R6: the last drained bit returns to an empty FILL
    p_drain_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        drain_last |=> ((st_q == CTL_FILL) && (cnt_q == '0)));

    // R7: steps offered during a drain do not move the count
    p_drain_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == CTL_DRAIN) && !drain_last) |=> $stable(cnt_q));

    // R9: an idle cycle leaves the count alone
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q != CTL_DRAIN) && !step_valid && !flush) |=> $stable(cnt_q));

endmodule

// File: rtl/rx_survivor_unit.sv
module rx_survivor_unit #(
    parameter int SURV_LEN   = 15,
    parameter int NUM_STATES = 4
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   step_valid,
    input  logic [NUM_STATES-1:0]                  decision,
    input  logic [$clog2(NUM_STATES)-1:0]          best_state,
    input  logic                                   flush,
    output logic                                   out_valid,
    output logic                                   out_bit
);

    localparam int STW  = $clog2(NUM_STATES);
    localparam int CW   = $clog2(SURV_LEN + 1);
    localparam int MASK = NUM_STATES - 1;

    logic [NUM_STATES-1:0][SURV_LEN-1:0] surv;
    logic                                upd;
    logic                                clr;
    logic [SURV_LEN-1:0]                 best_row;
    logic [STW-1:0]                      best_pred;
    logic                                best_drop;

    for (genvar g = 0; g < NUM_STATES; g++) begin : g_row
        localparam int LO = (g << 1) & MASK;
        rx_surv_row #(
            .LEN (SURV_LEN),
            .STW (STW),
            .IDX (g)
        ) u_row (
            .clk     (clk),
            .rst_n   (rst_n),
            .upd     (upd),
            .clr     (clr),
            .sel     (decision[g]),
            .from_lo (surv[LO]),
            .from_hi (surv[LO + 1]),
            .hist    (surv[g])
        );
    end

    always_comb begin
        best_row  = surv[best_state];
        best_pred = {best_state[STW-2:0], decision[best_state]};
        best_drop = surv[best_pred][SURV_LEN-1];
    end

    rx_ctrl #(
        .LEN (SURV_LEN),
        .CW  (CW)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_valid (step_valid),
        .flush      (flush),
        .best_row   (best_row),
        .best_drop  (best_drop),
        .upd        (upd),
        .clr        (clr),
        .out_valid  (out_valid),
        .out_bit    (out_bit)
    );

    // R1: the cycle after reset shows no output
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(!rst_n) |-> !out_valid);

    // R10: a flush in the same cycle as a step drops the step
    p_flush_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && step_valid) |-> !upd);

endmodule

// File: tb/test_rx_survivor_unit.sv
`timescale 1ns/1ps
module test_rx_survivor_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       step_valid = 1'b0;
    logic [3:0] decision = '0;
    logic [1:0] best_state = '0;
    logic       flush = 1'b0;
    logic       out_valid;
    logic       out_bit;

    int         checks = 0;
    int         fails  = 0;
    int         t      = 0;
    logic [3:0] hdec [0:511];
    logic       exp_q [$];
    string      tag_q [$];

    always #2.5 clk = ~clk;

    rx_survivor_unit i_rx_survivor_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_valid (step_valid),
        .decision   (decision),
        .best_state (best_state),
        .flush      (flush),
        .out_valid  (out_valid),
        .out_bit    (out_bit)
    );

    // walk back through recorded decisions: bit of the path 'depth' steps before t
    function automatic logic trace_bit(input logic [1:0] best, input int depth);
        logic [1:0] s;
        int tt;
        s  = best;
        tt = t;
        for (int k = 0; k < depth; k++) begin
            s  = {s[0], hdec[tt][s]};
            tt = tt - 1;
        end
        return s[1];
    endfunction

    task automatic do_step(input logic [3:0] dec, input logic [1:0] best, input string tag);
        @(negedge clk);
        step_valid = 1'b1;
        flush      = 1'b0;
        decision   = dec;
        best_state = best;
        t          = t + 1;
        hdec[t]    = dec;
        if (t >= 16) begin
            exp_q.push_back(trace_bit(best, 15));
            tag_q.push_back(tag);
        end
    endtask

    task automatic do_idle();
        @(negedge clk);
        step_valid = 1'b0;
        flush      = 1'b0;
        decision   = 4'($urandom);
    endtask

    task automatic do_flush(input logic [1:0] best, input logic with_step, input string tag);
        int n;
        @(negedge clk);
        flush      = 1'b1;
        step_valid = with_step;
        decision   = 4'($urandom);
        best_state = best;
        n = (t < 15) ? t : 15;
        for (int j = n - 1; j >= 0; j--) begin
            exp_q.push_back(trace_bit(best, j));
            tag_q.push_back(tag);
        end
        // R7: junk on every input while the drain runs
        for (int j = 0; j < n; j++) begin
            @(negedge clk);
            flush      = 1'($urandom);
            step_valid = 1'($urandom);
            decision   = 4'($urandom);
            best_state = 2'($urandom);
        end
        t = 0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R2: unexpected output bit=%0b, expected no output", out_bit);
            end else begin
                logic  e;
                string g;
                e = exp_q.pop_front();
                g = tag_q.pop_front();
                if (out_bit !== e) begin
                    fails++;
                    $display("FAIL %s: out_bit=%0b expected=%0b", g, out_bit, e);
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [1:0] s;
        logic [1:0] ps;
        logic       u;
        logic [7:0] pat;
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1: out_valid=%0b in reset, expected=0", out_valid);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1: out_valid=%0b after reset, expected=0", out_valid);
        end

        // R8: flush with nothing held
        do_flush(2'($urandom), 1'b0, "R8");
        repeat (3) do_idle();

        // R4: random decisions and best states through the fill and stream
        for (int i = 0; i < 40; i++) do_step(4'($urandom), 2'($urandom), "R4");
        // R5: full-register drain
        do_flush(2'($urandom), 1'b0, "R5");

        // R6: restart after the drain, partial fill, R3 via a non-path best state
        for (int i = 0; i < 6; i++) do_step(4'($urandom), 2'($urandom), "R6");
        do_flush(2'($urandom), 1'b0, "R3");

        // R9: stalls scattered through a stream
        for (int i = 0; i < 35; i++) begin
            do_step(4'($urandom), 2'($urandom), "R9");
            if ($urandom % 3 == 0) do_idle();
            if ($urandom % 5 == 0) do_idle();
        end
        // R10: step in the flush cycle is dropped
        do_flush(2'($urandom), 1'b1, "R10");

        // R10 with a short history
        for (int i = 0; i < 9; i++) do_step(4'($urandom), 2'($urandom), "R10");
        do_flush(2'($urandom), 1'b1, "R10");

        // R4: error-free encoded input, true path given as best state
        pat = 8'b0001_0110;
        s   = 2'b00;
        for (int i = 0; i < 32; i++) begin
            logic [3:0] dec;
            u   = pat[i % 8];
            ps  = s;
            s   = {u, ps[1]};
            dec = 4'($urandom);
            dec[s] = ps[0];
            do_step(dec, s, "R4");
        end
        do_flush(s, 1'b0, "R5");

        // R7: state after a junk-filled drain must be empty again
        for (int i = 0; i < 20; i++) do_step(4'($urandom), 2'($urandom), "R7");
        do_flush(2'($urandom), 1'b0, "R7");

        repeat (20) do_idle();
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R5: %0d expected bits never appeared, expected 0 left", exp_q.size());
        end
        summary();
        $finish;
    end

endmodule